// File: doc/BRIEF.md
# Concatenated Subpacket Stream Parser

This block sits behind a network interface that delivers 64-bit words, one per valid/ready handshake, with a flag on the last word of each network packet. A single network packet may carry several subpackets back to back. Each subpacket starts with a header word naming its type, a starting pixel address and a length in 32-bit data words. The data words follow, packed two per 64-bit word. A trailer word ends the subpacket, and a flag in the trailer can carry one last data word. The parser walks this structure and emits a stream of 32-bit items. Each item is tagged with the subpacket type and its own pixel address. The address starts at the header value and advances by one for each item.

Subpackets of the flush type are used only to push traffic through the network. They are consumed at full rate and produce no output. If a network packet ends before a subpacket has reached its trailer, a sticky error flag is raised. The parser then treats the next word as the header of a new packet, so later traffic is still parsed correctly.

Top module: `subpacket_parser`

## Requirements
- R1: After reset, out_valid is 0, err_trunc is 0 and in_ready is 1.
- R2: A header word is decoded as follows: type in bits [63:60], pixel address in bits [59:32], size in 32-bit words in bits [15:0]. The first item of the subpacket carries that type and that address. Each item appears on the outputs one cycle after the word that holds it is accepted.
- R3: A body word yields two items on consecutive cycles, its bits [31:0] first and its bits [63:32] second. Their addresses are consecutive. in_ready is 0 for exactly the one cycle in which the second item is emitted.
- R4: In a trailer word, bit 63 set to 1 emits bits [31:0] as one more item at the next address. Bit 63 set to 0 emits nothing, and the trailer's other bits are ignored.
- R5: A subpacket holds exactly floor(size/2) body words followed by one trailer. The word after the trailer is taken as the next header. A size of 0 means the header is followed directly by the trailer.
- R6: A subpacket whose type is 4'hF (flush) emits no item. All of its words, trailer included, are accepted with in_ready held at 1.
- R7: When in_eod arrives on a header word or a body word, err_trunc is set to 1 and stays at 1 until reset. Items from body words that did arrive are still emitted. The next accepted word is parsed as a header.
- R8: in_eod on a trailer ends the packet cleanly, without setting err_trunc. Several subpackets of mixed types may share one packet. Item addresses wrap modulo 2^28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser can accept a word this cycle |
| in_data | input | 64 | Input word |
| in_eod | input | 1 | Input word is the last of its network packet |
| out_valid | output | 1 | Item valid |
| out_type | output | 4 | Type of the subpacket the item belongs to |
| out_addr | output | 28 | Pixel address of the item |
| out_data | output | 32 | Item data |
| err_trunc | output | 1 | Sticky truncation error |

## Verification
On every cycle, the assertions check how a body word is split:
- a stalled input cycle is always followed by an item at the next address;
- the stall never lasts more than one cycle;
- a flush type never reaches the output.

They also check that the error flag only rises after an accepted end-of-packet word and never falls.

Only the bench's scenarios can show that item counts follow the size field and the trailer flag, that the boundary between subpackets lands on the right word, and that item data and starting addresses are correct. The same applies to recovery after truncation and to flush subpackets being consumed in the exact number of cycles.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam int WORD_W   = 64;
  localparam int ITEM_W   = 32;
  localparam int PAD_FLAG = 63;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_BODY = 2'd1,
    ST_PAD  = 2'd2
  } spp_state_e;
endpackage

// File: rtl/spp_hdr_decode.sv
module spp_hdr_decode #(
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 28,
  parameter int SIZE_W = 16,
  parameter logic [TYPE_W-1:0] FLUSH_CODE = '1
) (
  input  logic [spp_pkg::WORD_W-1:0] word,
  output logic [TYPE_W-1:0]          hdr_type,
  output logic [ADDR_W-1:0]          hdr_addr,
  output logic [SIZE_W-1:0]          body_words,
  output logic                       is_flush
);
  localparam int TYPE_LSB = spp_pkg::WORD_W - TYPE_W;
  localparam int ADDR_LSB = TYPE_LSB - ADDR_W;

  logic [SIZE_W-1:0] size_items;

  always_comb begin
    hdr_type   = word[TYPE_LSB +: TYPE_W];
    hdr_addr   = word[ADDR_LSB +: ADDR_W];
    size_items = word[SIZE_W-1:0];
    // two items per body word; an odd last item rides in the trailer
    body_words = size_items >> 1;
    is_flush   = (hdr_type == FLUSH_CODE);
  end
endmodule

// File: rtl/spp_emit_reg.sv
module spp_emit_reg #(
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 28
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [TYPE_W-1:0]          load_type,
  input  logic [ADDR_W-1:0]          load_addr,
  input  logic [spp_pkg::ITEM_W-1:0] load_data,
  output logic                       q_valid,
  output logic [TYPE_W-1:0]          q_type,
  output logic [ADDR_W-1:0]          q_addr,
  output logic [spp_pkg::ITEM_W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_type  <= '0;
      q_addr  <= '0;
      q_data  <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_type <= load_type;
        q_addr <= load_addr;
        q_data <= load_data;
      end
    end
  end
endmodule

// File: rtl/subpacket_parser.sv
module subpacket_parser #(
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 28,
  parameter int SIZE_W = 16,
  parameter logic [TYPE_W-1:0] FLUSH_CODE = '1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [spp_pkg::WORD_W-1:0] in_data,
  input  logic                       in_eod,
  output logic                       out_valid,
  output logic [TYPE_W-1:0]          out_type,
  output logic [ADDR_W-1:0]          out_addr,
  output logic [spp_pkg::ITEM_W-1:0] out_data,
  output logic                       err_trunc
);
  import spp_pkg::*;

  localparam int HALF = ITEM_W;

  spp_state_e          state;
  logic [SIZE_W-1:0]   remain;
  logic [TYPE_W-1:0]   cur_type;
  logic [ADDR_W-1:0]   cur_addr;
  logic                drop;
  logic                half_pend;
  logic [HALF-1:0]     half_data;
  logic                err_q;

  logic [TYPE_W-1:0]   hdr_type;
  logic [ADDR_W-1:0]   hdr_addr;
  logic [SIZE_W-1:0]   body_words;
  logic                is_flush;

  logic                accept;
  logic                emit;
  logic [HALF-1:0]     emit_data;

  spp_hdr_decode #(
    .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .FLUSH_CODE(FLUSH_CODE)
  ) u_dec (
    .word(in_data), .hdr_type(hdr_type), .hdr_addr(hdr_addr),
    .body_words(body_words), .is_flush(is_flush)
  );

  assign in_ready  = !half_pend;
  assign accept    = in_valid && in_ready;
  assign err_trunc = err_q;

  always_comb begin
    emit      = 1'b0;
    emit_data = in_data[HALF-1:0];
    if (half_pend) begin
      emit      = 1'b1;
      emit_data = half_data;
    end else if (accept && !drop) begin
      if (state == ST_BODY)     emit = 1'b1;
      else if (state == ST_PAD) emit = in_data[PAD_FLAG];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HDR;
      remain    <= '0;
      cur_type  <= '0;
      cur_addr  <= '0;
      drop      <= 1'b0;
      half_pend <= 1'b0;
      half_data <= '0;
      err_q     <= 1'b0;
    end else begin
      if (emit) cur_addr <= cur_addr + 1'b1;
      if (half_pend) begin
        half_pend <= 1'b0;
      end else if (accept) begin
        case (state)
          ST_HDR: begin
            cur_type <= hdr_type;
            cur_addr <= hdr_addr;
            drop     <= is_flush;
            remain   <= body_words;
            if (in_eod)                err_q <= 1'b1;
            else if (body_words == '0) state <= ST_PAD;
            else                       state <= ST_BODY;
          end
          ST_BODY: begin
            if (!drop) begin
              half_pend <= 1'b1;
              half_data <= in_data[2*HALF-1:HALF];
            end
            remain <= remain - 1'b1;
            if (in_eod) begin
              err_q <= 1'b1;
              state <= ST_HDR;
            end else if (remain == SIZE_W'(1)) begin
              state <= ST_PAD;
            end
          end
          default: state <= ST_HDR;
        endcase
      end
    end
  end

  spp_emit_reg #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .load(emit),
    .load_type(cur_type), .load_addr(cur_addr), .load_data(emit_data),
    .q_valid(out_valid), .q_type(out_type), .q_addr(out_addr), .q_data(out_data)
  );
endmodule

// File: rtl/subpacket_parser_chk.sv
module subpacket_parser_chk #(
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 28,
  parameter logic [TYPE_W-1:0] FLUSH_CODE = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_eod,
  input logic              out_valid,
  input logic [TYPE_W-1:0] out_type,
  input logic [ADDR_W-1:0] out_addr,
  input logic              err_trunc
);
  assert_split_follow_R3: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid);

  assert_split_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && out_valid) |=> (out_addr == ADDR_W'($past(out_addr) + 1'b1)));

  assert_ready_recovers_R3: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  assert_no_flush_out_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_type != FLUSH_CODE));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_trunc |=> err_trunc);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err_trunc) |-> $past(in_valid && in_ready && in_eod));
endmodule

bind subpacket_parser subpacket_parser_chk #(
  .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .FLUSH_CODE(FLUSH_CODE)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_eod(in_eod), .out_valid(out_valid), .out_type(out_type),
  .out_addr(out_addr), .err_trunc(err_trunc)
);

// File: tb/subpacket_parser_test.sv
module subpacket_parser_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_eod = 1'b0;
  logic        out_valid;
  logic [3:0]  out_type;
  logic [27:0] out_addr;
  logic [31:0] out_data;
  logic        err_trunc;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit active = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  subpacket_parser uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_eod(in_eod), .out_valid(out_valid),
    .out_type(out_type), .out_addr(out_addr), .out_data(out_data),
    .err_trunc(err_trunc)
  );

  function automatic logic [31:0] item_val(input int sp, input int k);
    return 32'hC0DE0000 + 32'(sp * 256 + k);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (active && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected item", {out_type, out_addr, out_data}, 64'h0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_type, out_addr, out_data} == e, t, "item {type,addr,data}",
              {out_type, out_addr, out_data}, e);
      end
    end
  end

  task automatic send_word(input logic [63:0] w, input bit eod);
    bit r;
    in_valid = 1'b1;
    in_data  = w;
    in_eod   = eod;
    do begin
      r = in_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!r);
    in_valid = 1'b0;
    in_eod   = 1'b0;
  endtask

  // one subpacket; the trailer carries eod when last is set
  task automatic send_sub(input logic [3:0] ty, input logic [27:0] base,
                          input int size, input bit tflag, input int sp,
                          input bit last);
    int nb;
    int k;
    nb = size / 2;
    k = 0;
    send_word({ty, base, 16'h0, 16'(size)}, 1'b0);
    for (int j = 0; j < nb; j++) begin
      if (ty != 4'hF) begin
        exp_q.push_back({ty, 28'(base + 28'(k)), item_val(sp, k)});
        tag_q.push_back(k == 0 ? "R2" : "R3");
        exp_q.push_back({ty, 28'(base + 28'(k + 1)), item_val(sp, k + 1)});
        tag_q.push_back("R3");
      end
      send_word({item_val(sp, k + 1), item_val(sp, k)}, 1'b0);
      k += 2;
    end
    if (tflag && ty != 4'hF) begin
      exp_q.push_back({ty, 28'(base + 28'(k)), item_val(sp, k)});
      tag_q.push_back("R4");
    end
    send_word({tflag, 31'h1234567, tflag ? item_val(sp, k) : 32'hDEADBEEF}, last);
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "items missing", 64'(exp_q.size()), 64'h0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int sp;
    int c0;
    sp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid", 64'(out_valid), 64'h0);
    check(err_trunc == 1'b0, "R1", "err_trunc", 64'(err_trunc), 64'h0);
    check(in_ready == 1'b1, "R1", "in_ready", 64'(in_ready), 64'h1);
    active = 1'b1;

    // R2 R3 R4 R5: sweep size, trailer flag and type, one subpacket per packet
    for (int ty = 1; ty < 3; ty++)
      for (int sz = 0; sz < 8; sz++)
        for (int tf = 0; tf < 2; tf++) begin
          send_sub(4'(ty), 28'(sp * 1000 + 5), sz, tf[0], sp, 1'b1);
          sp++;
        end
    drain("R5");
    check(err_trunc == 1'b0, "R8", "err after clean packets", 64'(err_trunc), 64'h0);

    // R3: in_ready drops for one cycle after a body word
    send_word({4'h2, 28'h100, 16'h0, 16'd2}, 1'b0);
    exp_q.push_back({4'h2, 28'h100, item_val(sp, 0)}); tag_q.push_back("R3");
    exp_q.push_back({4'h2, 28'h101, item_val(sp, 1)}); tag_q.push_back("R3");
    in_valid = 1'b1; in_data = {item_val(sp, 1), item_val(sp, 0)};
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R3", "in_ready during split", 64'(in_ready), 64'h0);
    @(negedge clk);
    check(in_ready == 1'b1, "R3", "in_ready after split", 64'(in_ready), 64'h1);
    send_word({1'b0, 63'h0}, 1'b1);
    sp++;
    drain("R3");

    // R8: several subpackets including a flush share one packet, address wrap
    send_sub(4'h3, 28'hFFFFFFE, 5, 1'b1, sp, 1'b0); sp++;
    send_sub(4'hF, 28'h0000200, 5, 1'b1, sp, 1'b0); sp++;
    send_sub(4'h1, 28'h0000300, 3, 1'b1, sp, 1'b0); sp++;
    send_sub(4'h2, 28'h0000400, 0, 1'b0, sp, 1'b1); sp++;
    send_sub(4'h4, 28'h0000500, 4, 1'b0, sp, 1'b1); sp++;
    drain("R8");
    check(err_trunc == 1'b0, "R8", "err after multi-subpacket", 64'(err_trunc), 64'h0);

    // R6: flush subpackets emit nothing and take exactly one cycle per word
    for (int sz = 0; sz < 6; sz++) begin
      c0 = cycles;
      send_sub(4'hF, 28'h77, sz, sz[0], sp, 1'b1);
      sp++;
      check(cycles - c0 == 2 + sz / 2, "R6", "flush cycles",
            64'(cycles - c0), 64'(2 + sz / 2));
    end
    drain("R6");

    // R7: truncation inside the body; items that arrived still come out
    send_word({4'h5, 28'h900, 16'h0, 16'd6}, 1'b0);
    exp_q.push_back({4'h5, 28'h900, item_val(sp, 0)}); tag_q.push_back("R7");
    exp_q.push_back({4'h5, 28'h901, item_val(sp, 1)}); tag_q.push_back("R7");
    send_word({item_val(sp, 1), item_val(sp, 0)}, 1'b1);
    sp++;
    drain("R7");
    check(err_trunc == 1'b1, "R7", "err after body eod", 64'(err_trunc), 64'h1);
    // R7: next word is a header again
    send_sub(4'h6, 28'hA00, 3, 1'b1, sp, 1'b1); sp++;
    drain("R7");
    // R7: truncation on a header, flag stays set, parsing recovers
    send_word({4'h6, 28'hB00, 16'h0, 16'd4}, 1'b1);
    send_sub(4'h7, 28'hC00, 2, 1'b0, sp, 1'b1); sp++;
    drain("R7");
    check(err_trunc == 1'b1, "R7", "err sticky", 64'(err_trunc), 64'h1);

    active = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule